// File: doc/BRIEF.md
# Write-strobe clocked control register bank

This block holds a set of control words that a processor loads through an asynchronous port. The port has an active-low select, an active-low write enable, a word address and a data bus. No flip-flop in the bank runs on the pipeline clock. A strobe is formed from select and write enable together, and it is high only while both are low. That strobe is the clock for every storage flip-flop. The words therefore change only during processor write cycles.

Each word has its own address comparator and a hold multiplexer in front of its flip-flops. On a strobe edge, the word whose address matches reloads. Every other word feeds its own output back and keeps its value. The stored words leave the block as one flat vector that drives a downstream pipeline. A read cycle puts the addressed word on the bus. The bus pad itself sits outside the block, so the bidirectional bus is split into an input, an output and an output enable.

In test-hold mode, the data to be stored does not come straight from the bus. It comes from a capture stage of one flip-flop per bus bit, clocked by the same strobe. A scan chain can therefore reach the data inputs of every control word.

Top module: `ctrlbank_top`

## Requirements
- R1: The strobe rises only when select and write enable are both low, whichever of the two falls last. A select-only low phase or a write-enable-only low phase changes no word.
- R2: With test_hold=0, a strobe rising edge loads data_i into the word whose index equals addr_i. Word k occupies bits [16k+15:16k] of ctrl_words_o.
- R3: On a strobe edge, every word whose index differs from addr_i keeps its value. An address from 8 to 15 writes no word.
- R4: A word takes the bus value present at the strobe rising edge. Changes to data_i while the strobe stays high, and at its falling edge, have no effect.
- R5: With cs_n=0, we_n=1 and addr_i below 8, data_oe=1 and data_o carries the addressed word.
- R6: data_oe=0 in every other case: select high, a write cycle in progress, or a read of an address from 8 to 15.
- R7: A read cycle leaves every word unchanged.
- R8: With test_hold=1, an addressed word loads the capture stage, which holds the data_i value of the previous strobe edge. That previous edge may have had any address.
- R9: we_n must be 0 whenever test_hold is 1.
- R10: rst=1 clears every word and the capture stage to zero at once, without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high asynchronous clear |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| test_hold | input | 1 | Selects the capture stage as the source of write data |
| addr_i | input | 4 | Word address |
| data_i | input | 16 | Bus input side |
| data_o | output | 16 | Bus output side, the read-back word |
| data_oe | output | 1 | Bus output enable |
| ctrl_words_o | output | 128 | All control words, word k in bits [16k+15:16k] |

## Verification
Writes are tried with walking, all-ones, all-zeros and alternating-bit patterns to every word. After each write the whole output vector is compared, so a wrong decode and a missing hold give different faulty words. Strobe-ordering patterns are also tried: select alone, write enable alone, and data changed after the strobe edge. These separate edge capture from level capture. Test-hold sequences use addresses that alternate between in-range and out-of-range. This shows that a word receives the previous cycle's bus value rather than the current one. Reads of in-range and out-of-range addresses separate the enable decode from the data multiplexer.

// File: rtl/ctrlbank_pkg.sv
package ctrlbank_pkg;

    localparam int unsigned CB_DATA_W    = 16;
    localparam int unsigned CB_NUM_WORDS = 8;
    localparam int unsigned CB_ADDR_W    = 4;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    function automatic cyc_e cyc_decode(input logic cs_n, input logic we_n);
        if (cs_n)
            return CYC_IDLE;
        else if (we_n)
            return CYC_READ;
        else
            return CYC_WRITE;
    endfunction

    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctrlbank_cycle_decode.sv
module ctrlbank_cycle_decode
    import ctrlbank_pkg::*;
(
    input  logic cs_n,
    input  logic we_n,
    output logic wr_strobe,
    output logic rd_active
);

    cyc_e cyc;

    always_comb begin
        cyc       = cyc_decode(cs_n, we_n);
        wr_strobe = (cyc == CYC_WRITE);
        rd_active = (cyc == CYC_READ);
    end

endmodule

// File: rtl/ctrlbank_capture.sv
module ctrlbank_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              wr_strobe,
    input  logic              rst,
    input  logic              test_hold,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] load_data
);

    logic [DATA_W-1:0] cap_q;

    // one flop per bus bit, same strobe clock as the words
    always_ff @(posedge wr_strobe or posedge rst) begin
        if (rst)
            cap_q <= '0;
        else
            cap_q <= data_i;
    end

    always_comb begin
        load_data = test_hold ? cap_q : data_i;
    end

endmodule

// File: rtl/ctrlbank_word.sv
module ctrlbank_word #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned MY_ADDR = 0
) (
    input  logic              wr_strobe,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] word_o
);

    logic              hit;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    always_comb begin
        hit    = (addr_i == ADDR_W'(MY_ADDR));
        word_d = hit ? load_data : word_q;   // hold multiplexer
    end

    always_ff @(posedge wr_strobe or posedge rst) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/ctrlbank_readback.sv
module ctrlbank_readback
    import ctrlbank_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic [NUM_WORDS*DATA_W-1:0] words_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        rd_active,
    output logic [DATA_W-1:0]           data_o,
    output logic                        data_oe
);

    localparam int unsigned SEL_W = sel_width(NUM_WORDS);

    logic [DATA_W-1:0] word_arr [NUM_WORDS];
    logic              in_range;
    logic [SEL_W-1:0]  sel;

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_split
        assign word_arr[k] = words_i[k*DATA_W +: DATA_W];
    end

    always_comb begin
        in_range = (int'(addr_i) < int'(NUM_WORDS));
        sel      = SEL_W'(addr_i);
        data_oe  = rd_active && in_range;
        data_o   = data_oe ? word_arr[sel] : '0;
    end

endmodule

// File: rtl/ctrlbank_top.sv
module ctrlbank_top
    import ctrlbank_pkg::*;
#(
    parameter int unsigned DATA_W    = CB_DATA_W,
    parameter int unsigned NUM_WORDS = CB_NUM_WORDS,
    parameter int unsigned ADDR_W    = CB_ADDR_W
) (
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        we_n,
    input  logic                        test_hold,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           data_i,
    output logic [DATA_W-1:0]           data_o,
    output logic                        data_oe,
    output logic [NUM_WORDS*DATA_W-1:0] ctrl_words_o
);

    logic              wr_strobe;
    logic              rd_active;
    logic [DATA_W-1:0] load_data;

    ctrlbank_cycle_decode u_dec (
        .cs_n      (cs_n),
        .we_n      (we_n),
        .wr_strobe (wr_strobe),
        .rd_active (rd_active)
    );

    ctrlbank_capture #(.DATA_W(DATA_W)) u_cap (
        .wr_strobe (wr_strobe),
        .rst       (rst),
        .test_hold (test_hold),
        .data_i    (data_i),
        .load_data (load_data)
    );

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        ctrlbank_word #(
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W),
            .MY_ADDR (k)
        ) u_word (
            .wr_strobe (wr_strobe),
            .rst       (rst),
            .addr_i    (addr_i),
            .load_data (load_data),
            .word_o    (ctrl_words_o[k*DATA_W +: DATA_W])
        );
    end

    ctrlbank_readback #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_rb (
        .words_i   (ctrl_words_o),
        .addr_i    (addr_i),
        .rd_active (rd_active),
        .data_o    (data_o),
        .data_oe   (data_oe)
    );

endmodule

// File: rtl/ctrlbank_checker.sv
module ctrlbank_checker #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned ADDR_W    = 4
) (
    input logic                        rst,
    input logic                        cs_n,
    input logic                        we_n,
    input logic                        test_hold,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [DATA_W-1:0]           data_i,
    input logic [NUM_WORDS*DATA_W-1:0] ctrl_words_o
);

    logic       chk_strobe;
    logic [1:0] arm_cnt;   // strobe edges seen since the last reset, saturating

    assign chk_strobe = !cs_n && !we_n;

    always_ff @(posedge chk_strobe or posedge rst) begin
        if (rst)
            arm_cnt <= '0;
        else if (arm_cnt != 2'd3)
            arm_cnt <= arm_cnt + 2'd1;
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_chk
        // R3: an unaddressed word is unchanged across a strobe edge
        assert_word_hold_R3: assert property (@(posedge chk_strobe) disable iff (rst)
            (arm_cnt >= 2'd1 && $past(addr_i) != ADDR_W'(k))
            |-> $stable(ctrl_words_o[k*DATA_W +: DATA_W]));

        // R2: an addressed word holds the bus value of that edge
        assert_word_load_R2: assert property (@(posedge chk_strobe) disable iff (rst)
            (arm_cnt >= 2'd1 && $past(addr_i) == ADDR_W'(k) && !$past(test_hold))
            |-> ctrl_words_o[k*DATA_W +: DATA_W] == $past(data_i));

        // R8: in test hold the word takes the bus value of the edge before
        assert_hold_path_R8: assert property (@(posedge chk_strobe) disable iff (rst)
            (arm_cnt >= 2'd2 && $past(addr_i) == ADDR_W'(k) && $past(test_hold))
            |-> ctrl_words_o[k*DATA_W +: DATA_W] == $past(data_i, 2));
    end

    // R9: test hold only with write enable low
    always_comb begin
        if (!rst && test_hold)
            assert_hold_we_R9: assert (!we_n);
    end

endmodule

bind ctrlbank_top ctrlbank_checker #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .rst          (rst),
    .cs_n         (cs_n),
    .we_n         (we_n),
    .test_hold    (test_hold),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .ctrl_words_o (ctrl_words_o)
);

// File: tb/ctrlbank_top_tb_top.sv
`timescale 1ns/1ps
module ctrlbank_top_tb_top;

    localparam int W  = 16;
    localparam int N  = 8;
    localparam int AW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           cs_n;
    logic           we_n;
    logic           test_hold;
    logic [AW-1:0]  addr_i;
    logic [W-1:0]   data_i;
    logic [W-1:0]   data_o;
    logic           data_oe;
    logic [N*W-1:0] ctrl_words_o;

    always #5 clk = ~clk;

    ctrlbank_top dut_i (
        .rst          (rst),
        .cs_n         (cs_n),
        .we_n         (we_n),
        .test_hold    (test_hold),
        .addr_i       (addr_i),
        .data_i       (data_i),
        .data_o       (data_o),
        .data_oe      (data_oe),
        .ctrl_words_o (ctrl_words_o)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    logic [W-1:0] model [N];
    logic [W-1:0] cap_model;

    typedef struct {
        logic         oe;
        logic [W-1:0] d;
        int           a;
    } exp_t;

    exp_t exp_q[$];
    event rd_sample;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] want);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, want);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] got;
            got = ctrl_words_o[k*W +: W];
            check(got === model[k], req, $sformatf("word %0d", k), got, model[k]);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < N; k++) model[k] = '0;
        cap_model = '0;
    endtask

    // write cycle; in test-hold mode we_n stays low throughout
    task automatic wr(input int a, input logic [W-1:0] d, input bit th);
        @(posedge clk); #1;
        addr_i = AW'(a);
        data_i = d;
        we_n   = 1'b0;
        @(posedge clk); #1;
        cs_n = 1'b0;                        // strobe rises here
        if (th) begin
            if (a < N) model[a] = cap_model;
        end else begin
            if (a < N) model[a] = d;
        end
        cap_model = d;
        @(negedge clk);
        check(data_oe === 1'b0, "R6", "oe during write", {15'd0, data_oe}, '0);
        @(posedge clk); #1;
        data_i = ~d;                        // R4: disturb while strobe is high
        @(posedge clk); #1;
        cs_n = 1'b1;
        if (!th) we_n = 1'b1;
        @(negedge clk);
        check_all(th ? "R8" : "R2/R3/R4");
    endtask

    task automatic rd(input int a);
        exp_t e;
        @(posedge clk); #1;
        addr_i = AW'(a);
        we_n   = 1'b1;
        cs_n   = 1'b0;
        e.a  = a;
        e.oe = (a < N);
        e.d  = (a < N) ? model[a] : '0;
        exp_q.push_back(e);
        @(negedge clk);
        ->rd_sample;
        @(posedge clk); #1;
        cs_n = 1'b1;
        @(negedge clk);
        check_all("R7");
        check(data_oe === 1'b0, "R6", "oe after read", {15'd0, data_oe}, '0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(rd_sample);
            #0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "read with empty queue", '0, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(data_oe === e.oe, e.oe ? "R5" : "R6",
                      $sformatf("oe addr %0d", e.a), {15'd0, data_oe}, {15'd0, e.oe});
                if (e.oe)
                    check(data_o === e.d, "R5", $sformatf("data addr %0d", e.a), data_o, e.d);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; we_n = 1'b1; test_hold = 1'b0;
        addr_i = '0; data_i = '0;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R10");
        check(data_oe === 1'b0, "R6", "oe idle at reset", {15'd0, data_oe}, '0);
        rst = 1'b0;

        // R2/R3: walking patterns in every word
        for (int k = 0; k < N; k++) wr(k, 16'h0001 << (k * 2) | 16'(k << 12), 1'b0);
        // R5/R7: read them all back
        for (int k = 0; k < N; k++) rd(k);

        // R3: out-of-range writes; R6: out-of-range read
        wr(9, 16'hBEEF, 1'b0);
        wr(15, 16'hDEAD, 1'b0);
        rd(12);

        // R1: select low alone (read phase) and write enable low alone
        @(posedge clk); #1;
        addr_i = 4'd3; data_i = 16'h7777; cs_n = 1'b0; we_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        data_i = 16'h8888;
        @(posedge clk); #1;
        cs_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        @(posedge clk); #1;
        we_n = 1'b0; data_i = 16'h9999; addr_i = 4'd4;
        repeat (2) @(posedge clk); #1;
        data_i = 16'h6666;
        @(posedge clk); #1;
        we_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R1: strobe formed by write enable falling last
        @(posedge clk); #1;
        addr_i = 4'd6; data_i = 16'h1357; cs_n = 1'b0;
        @(posedge clk); #1;
        we_n = 1'b0;
        model[6] = 16'h1357;
        cap_model = 16'h1357;
        @(posedge clk); #1;
        we_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // alternating and extreme patterns
        wr(0, 16'hFFFF, 1'b0);
        wr(7, 16'h5555, 1'b0);
        wr(3, 16'hAAAA, 1'b0);
        wr(7, 16'h0000, 1'b0);
        rd(0); rd(7); rd(3);

        // R8/R9: test-hold mode, write enable held low
        @(posedge clk); #1;
        we_n = 1'b0;
        @(posedge clk); #1;
        test_hold = 1'b1;
        wr(2, 16'hA5A5, 1'b1);
        wr(5, 16'h0F0F, 1'b1);
        wr(11, 16'h1234, 1'b1);
        wr(1, 16'hC3C3, 1'b1);
        @(posedge clk); #1;
        test_hold = 1'b0;
        @(posedge clk); #1;
        we_n = 1'b1;
        rd(2); rd(5); rd(1);

        // R10: reset in the middle of operation
        @(posedge clk); #1;
        rst = 1'b1;
        clear_model();
        @(negedge clk);
        check_all("R10");
        @(posedge clk); #1;
        rst = 1'b0;
        rd(4);
        wr(4, 16'h4242, 1'b0);
        rd(4);

        @(negedge clk);
        check(data_oe === 1'b0, "R6", "oe idle at end", {15'd0, data_oe}, '0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule